// File: doc/BRIEF.md
# Fixed-Point Load/Store Effective Address Unit

This block forms the memory address for integer load and store operations. Each cycle it can accept one operation: a base register index and value, an index register value, the target or source register index, a 16-bit immediate field, the immediate kind, a flag for the address-updating variant and a load/store flag. It adds the base and the selected offset to give a 64-bit effective address. The offset is a sign-extended displacement, a displacement scaled by four or by sixteen, or the index register value.

For the updating variants, the block also decides whether the computed address is written back into the base register. It flags register combinations that are not allowed for those variants. In that case it raises an invalid indication and suppresses the write-back. The result is registered, so it appears one clock after the operation is presented. A downstream issue or write-back stage consumes it. Memory access, translation and data formatting are handled elsewhere.

Top module: `ea_unit`

## Requirements
- R1: A result appears exactly one clock after an accepted operation: `o_valid` is high in the cycle after `i_valid` was high and low otherwise. Synchronous reset drives `o_valid`, `o_ea`, `o_wb_en`, `o_wb_idx` and `o_invalid` to zero.
- R2: For non-updating operations the base is zero when `i_ra_idx` is 0, and `i_ra_val` otherwise.
- R3: With `i_kind` = 2'b00 (plain displacement), the offset is `i_imm[15:0]` sign-extended to 64 bits.
- R4: With `i_kind` = 2'b01 (word-scaled displacement), the offset is `{i_imm[13:0], 2'b00}` sign-extended from bit 15. `i_imm[15:14]` has no effect.
- R5: With `i_kind` = 2'b10 (quad-scaled displacement), the offset is `{i_imm[11:0], 4'b0000}` sign-extended from bit 15. `i_imm[15:12]` has no effect.
- R6: With `i_kind` = 2'b11 (indexed), the offset is `i_rb_val`, and `i_imm` has no effect. All additions wrap modulo 2^64.
- R7: For updating operations (`i_update` = 1) the base is always `i_ra_val`, even when `i_ra_idx` is 0. A valid update drives `o_wb_en` = 1 and `o_wb_idx` = the base register index.
- R8: An updating load (`i_is_store` = 0) is invalid when `i_ra_idx` is 0 or when `i_ra_idx` equals `i_rt_idx`. Then `o_invalid` = 1 and `o_wb_en` = 0.
- R9: An updating store (`i_is_store` = 1) is invalid only when `i_ra_idx` is 0. A store whose source index equals the base index is valid and writes back.
- R10: Non-updating operations never raise `o_invalid` or `o_wb_en`, whatever the register indices are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Operation present this cycle |
| i_ra_idx | input | 5 | Base register index |
| i_ra_val | input | 64 | Base register value |
| i_rb_val | input | 64 | Index register value |
| i_rt_idx | input | 5 | Load target / store source register index |
| i_imm | input | 16 | Raw immediate field |
| i_kind | input | 2 | Offset kind: 00 disp, 01 word-scaled, 10 quad-scaled, 11 indexed |
| i_update | input | 1 | Address-updating variant |
| i_is_store | input | 1 | 1 = store, 0 = load |
| o_valid | output | 1 | Result valid |
| o_ea | output | 64 | Effective address |
| o_wb_en | output | 1 | Write address back to base register |
| o_wb_idx | output | 5 | Register index for the write-back |
| o_invalid | output | 1 | Illegal updating form detected |

## Verification
The only state is the output register. A wrong selection of base or offset therefore shows as a wrong `o_ea` in the very next cycle, and a wrong form decision shows as a wrong `o_wb_en` or `o_invalid` pairing in that same cycle. The bench attacks the corners where a slip would hide: register 0 as base with and without update, scaled immediates with their sign bit set and garbage in the ignored top bits, wrap-around additions, and equal base and target indices for both loads and stores. Any stale or delayed result breaks the one-cycle pairing between `i_valid` and `o_valid`, and the scoreboard catches that at once.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int XLEN    = 64;
    localparam int IDX_W   = 5;
    localparam int IMM_W   = 16;
    localparam int KIND_W  = 2;

    typedef enum logic [KIND_W-1:0] {
        OFS_DISP  = 2'b00,
        OFS_WORD  = 2'b01,
        OFS_QUAD  = 2'b10,
        OFS_INDEX = 2'b11
    } ofs_kind_e;

    typedef struct packed {
        logic             valid;
        logic [XLEN-1:0]  ea;
        logic             wb_en;
        logic [IDX_W-1:0] wb_idx;
        logic             invalid;
    } ea_result_t;

    // Take the low fld_w bits of imm, place them shift bits up with zeros
    // underneath, then replicate the field's top bit over the upper bits.
    function automatic logic [XLEN-1:0] scale_sext(
        input logic [IMM_W-1:0] imm,
        input int               fld_w,
        input int               shift
    );
        logic [XLEN-1:0] r;
        for (int i = 0; i < XLEN; i++) begin
            if (i < shift)
                r[i] = 1'b0;
            else if (i - shift < fld_w)
                r[i] = imm[i - shift];
            else
                r[i] = imm[fld_w - 1];
        end
        return r;
    endfunction

endpackage

// File: rtl/ea_base_sel.sv
module ea_base_sel
    import ea_pkg::*;
(
    input  logic [IDX_W-1:0] ra_idx,
    input  logic [XLEN-1:0]  ra_val,
    input  logic             update,
    output logic [XLEN-1:0]  base
);
    logic ra_is_zero;

    assign ra_is_zero = (ra_idx == '0);

    always_comb begin
        if (update || !ra_is_zero)
            base = ra_val;
        else
            base = '0;
    end
endmodule

// File: rtl/ea_offset_gen.sv
module ea_offset_gen
    import ea_pkg::*;
#(
    parameter int DISP_W  = 16,
    parameter int WORD_W  = 14,
    parameter int QUAD_W  = 12,
    parameter int WORD_SH = 2,
    parameter int QUAD_SH = 4
) (
    input  logic [IMM_W-1:0]  imm,
    input  ofs_kind_e         kind,
    input  logic [XLEN-1:0]   rb_val,
    output logic [XLEN-1:0]   offset
);
    localparam int NUM_IMM = 3;

    logic [XLEN-1:0] imm_ofs [NUM_IMM];

    for (genvar g = 0; g < NUM_IMM; g++) begin : g_imm
        localparam int FW = (g == 0) ? DISP_W : (g == 1) ? WORD_W : QUAD_W;
        localparam int SH = (g == 0) ? 0      : (g == 1) ? WORD_SH : QUAD_SH;
        assign imm_ofs[g] = scale_sext(imm, FW, SH);
    end

    always_comb begin
        unique case (kind)
            OFS_DISP:  offset = imm_ofs[0];
            OFS_WORD:  offset = imm_ofs[1];
            OFS_QUAD:  offset = imm_ofs[2];
            default:   offset = rb_val;
        endcase
    end
endmodule

// File: rtl/ea_form_chk.sv
module ea_form_chk
    import ea_pkg::*;
(
    input  logic             valid,
    input  logic             update,
    input  logic             is_store,
    input  logic [IDX_W-1:0] ra_idx,
    input  logic [IDX_W-1:0] rt_idx,
    output logic             wb_en,
    output logic             invalid
);
    logic ra_zero;
    logic ra_clash;
    logic bad_form;

    assign ra_zero  = (ra_idx == '0);
    assign ra_clash = !is_store && (ra_idx == rt_idx);
    assign bad_form = ra_zero || ra_clash;

    always_comb begin
        wb_en   = 1'b0;
        invalid = 1'b0;
        if (valid && update) begin
            invalid = bad_form;
            wb_en   = !bad_form;
        end
    end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
#(
    parameter int DISP_W  = 16,
    parameter int WORD_W  = 14,
    parameter int QUAD_W  = 12,
    parameter int WORD_SH = 2,
    parameter int QUAD_SH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             i_valid,
    input  logic [4:0]       i_ra_idx,
    input  logic [63:0]      i_ra_val,
    input  logic [63:0]      i_rb_val,
    input  logic [4:0]       i_rt_idx,
    input  logic [15:0]      i_imm,
    input  logic [1:0]       i_kind,
    input  logic             i_update,
    input  logic             i_is_store,
    output logic             o_valid,
    output logic [63:0]      o_ea,
    output logic             o_wb_en,
    output logic [4:0]       o_wb_idx,
    output logic             o_invalid
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;
    logic            wb_en_c;
    logic            invalid_c;
    ea_result_t      nxt;
    ea_result_t      res_q;

    ea_base_sel u_base (
        .ra_idx (i_ra_idx),
        .ra_val (i_ra_val),
        .update (i_update),
        .base   (base)
    );

    ea_offset_gen #(
        .DISP_W  (DISP_W),
        .WORD_W  (WORD_W),
        .QUAD_W  (QUAD_W),
        .WORD_SH (WORD_SH),
        .QUAD_SH (QUAD_SH)
    ) u_ofs (
        .imm    (i_imm),
        .kind   (ofs_kind_e'(i_kind)),
        .rb_val (i_rb_val),
        .offset (offset)
    );

    ea_form_chk u_chk_form (
        .valid    (i_valid),
        .update   (i_update),
        .is_store (i_is_store),
        .ra_idx   (i_ra_idx),
        .rt_idx   (i_rt_idx),
        .wb_en    (wb_en_c),
        .invalid  (invalid_c)
    );

    always_comb begin
        nxt         = res_q;
        nxt.valid   = i_valid;
        nxt.wb_en   = wb_en_c;
        nxt.invalid = invalid_c;
        if (i_valid) begin
            nxt.ea     = base + offset;
            nxt.wb_idx = i_ra_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            res_q <= '0;
        else
            res_q <= nxt;
    end

    assign o_valid   = res_q.valid;
    assign o_ea      = res_q.ea;
    assign o_wb_en   = res_q.wb_en;
    assign o_wb_idx  = res_q.wb_idx;
    assign o_invalid = res_q.invalid;
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        i_valid,
    input logic [4:0]  i_ra_idx,
    input logic [63:0] i_rb_val,
    input logic [4:0]  i_rt_idx,
    input logic [1:0]  i_kind,
    input logic        i_update,
    input logic        i_is_store,
    input logic        o_valid,
    input logic [63:0] o_ea,
    input logic        o_wb_en,
    input logic [4:0]  o_wb_idx,
    input logic        o_invalid
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        i_valid |=> o_valid);                                          // R1
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !i_valid |=> !o_valid);                                        // R1
    AST_ZERO_BASE_INDEXED: assert property (@(posedge clk) disable iff (rst)
        (i_valid && !i_update && i_ra_idx == 5'd0 && i_kind == 2'b11)
        |=> (o_ea == $past(i_rb_val)));                                // R2
    AST_WB_INDEX: assert property (@(posedge clk) disable iff (rst)
        (i_valid && i_update) |=> (o_wb_idx == $past(i_ra_idx)));      // R7
    AST_LOAD_CLASH: assert property (@(posedge clk) disable iff (rst)
        (i_valid && i_update && !i_is_store && i_ra_idx == i_rt_idx)
        |=> (o_invalid && !o_wb_en));                                  // R8
    AST_STORE_SAME_OK: assert property (@(posedge clk) disable iff (rst)
        (i_valid && i_update && i_is_store && i_ra_idx != 5'd0)
        |=> (o_wb_en && !o_invalid));                                  // R9
    AST_NO_UPDATE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (i_valid && !i_update) |=> (!o_wb_en && !o_invalid));          // R10
    AST_EXCLUSIVE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        !(o_wb_en && o_invalid));                                      // R8
    AST_WB_NONZERO: assert property (@(posedge clk) disable iff (rst)
        o_wb_en |-> (o_valid && o_wb_idx != 5'd0));                    // R7
endmodule

bind ea_unit ea_unit_chk u_ea_unit_chk (
    .clk        (clk),
    .rst        (rst),
    .i_valid    (i_valid),
    .i_ra_idx   (i_ra_idx),
    .i_rb_val   (i_rb_val),
    .i_rt_idx   (i_rt_idx),
    .i_kind     (i_kind),
    .i_update   (i_update),
    .i_is_store (i_is_store),
    .o_valid    (o_valid),
    .o_ea       (o_ea),
    .o_wb_en    (o_wb_en),
    .o_wb_idx   (o_wb_idx),
    .o_invalid  (o_invalid)
);

// File: tb/test_ea_unit.sv
`timescale 1ns/1ps
module test_ea_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        i_valid = 1'b0;
    logic [4:0]  i_ra_idx = '0;
    logic [63:0] i_ra_val = '0;
    logic [63:0] i_rb_val = '0;
    logic [4:0]  i_rt_idx = '0;
    logic [15:0] i_imm = '0;
    logic [1:0]  i_kind = '0;
    logic        i_update = 1'b0;
    logic        i_is_store = 1'b0;
    logic        o_valid;
    logic [63:0] o_ea;
    logic        o_wb_en;
    logic [4:0]  o_wb_idx;
    logic        o_invalid;

    typedef struct {
        logic [63:0] ea;
        logic        wb_en;
        logic [4:0]  wb_idx;
        logic        invalid;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;

    always #10 clk = ~clk;

    ea_unit i_ea_unit (
        .clk(clk), .rst(rst), .i_valid(i_valid), .i_ra_idx(i_ra_idx),
        .i_ra_val(i_ra_val), .i_rb_val(i_rb_val), .i_rt_idx(i_rt_idx),
        .i_imm(i_imm), .i_kind(i_kind), .i_update(i_update),
        .i_is_store(i_is_store), .o_valid(o_valid), .o_ea(o_ea),
        .o_wb_en(o_wb_en), .o_wb_idx(o_wb_idx), .o_invalid(o_invalid)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] model_ea(
        input logic [4:0] ra_idx, input logic [63:0] ra_val,
        input logic [63:0] rb, input logic [15:0] imm,
        input logic [1:0] kind, input logic upd);
        logic [63:0] base;
        logic [63:0] ofs;
        base = (upd || ra_idx != 5'd0) ? ra_val : 64'd0;
        case (kind)
            2'b00:   ofs = {{48{imm[15]}}, imm};
            2'b01:   ofs = {{48{imm[13]}}, imm[13:0], 2'b00};
            2'b10:   ofs = {{48{imm[11]}}, imm[11:0], 4'b0000};
            default: ofs = rb;
        endcase
        return base + ofs;
    endfunction

    task automatic send(input string tag, input logic [4:0] ra_idx,
                        input logic [63:0] ra_val, input logic [63:0] rb,
                        input logic [4:0] rt_idx, input logic [15:0] imm,
                        input logic [1:0] kind, input logic upd,
                        input logic st);
        exp_t e;
        logic bad;
        @(negedge clk);
        i_valid = 1'b1; i_ra_idx = ra_idx; i_ra_val = ra_val;
        i_rb_val = rb; i_rt_idx = rt_idx; i_imm = imm; i_kind = kind;
        i_update = upd; i_is_store = st;
        bad       = upd && (ra_idx == 5'd0 || (!st && ra_idx == rt_idx));
        e.ea      = model_ea(ra_idx, ra_val, rb, imm, kind, upd);
        e.wb_en   = upd && !bad;
        e.wb_idx  = ra_idx;
        e.invalid = bad;
        e.tag     = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            i_valid = 1'b0;
            i_ra_idx = 5'd9; i_update = 1'b1; i_is_store = 1'b0;
        end
    endtask

    // Monitor: compares outputs mid-cycle against the scoreboard queue.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (!rst) begin
                if (o_valid) begin
                    if (exp_q.size() == 0) begin
                        check("R1", "unexpected o_valid", 64'd1, 64'd0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(e.tag, "ea", o_ea, e.ea);
                        check(e.tag, "wb_en", 64'(o_wb_en), 64'(e.wb_en));
                        check(e.tag, "invalid", 64'(o_invalid), 64'(e.invalid));
                        if (e.wb_en)
                            check(e.tag, "wb_idx", 64'(o_wb_idx), 64'(e.wb_idx));
                    end
                end else begin
                    check("R1", "idle flags", {62'd0, o_wb_en, o_invalid}, 64'd0);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "reset valid", 64'(o_valid), 64'd0);
        check("R1", "reset ea", o_ea, 64'd0);
        check("R1", "reset flags", {61'd0, o_wb_en, o_invalid, o_wb_idx != 0}, 64'd0);
        rst = 1'b0;

        // R2/R3: register 0 base reads as zero, negative displacement
        send("R2", 5'd0, 64'hDEAD_BEEF_0000_1111, 64'd0, 5'd4, 16'h8000, 2'b00, 1'b0, 1'b0);
        // R3: positive max displacement
        send("R3", 5'd3, 64'h0000_0000_0001_0000, 64'd5, 5'd4, 16'h7FFF, 2'b00, 1'b0, 1'b0);
        // R4: word-scaled, negative, garbage in ignored top bits
        send("R4", 5'd5, 64'h0000_0000_0000_1000, 64'd0, 5'd1, 16'hE001, 2'b01, 1'b0, 1'b0);
        send("R4", 5'd5, 64'h0000_0000_0000_1000, 64'd0, 5'd1, 16'h1FFF, 2'b01, 1'b0, 1'b1);
        // R5: quad-scaled, negative and positive with ignored bits set
        send("R5", 5'd6, 64'h0000_0000_0001_0000, 64'd0, 5'd2, 16'hF801, 2'b10, 1'b0, 1'b0);
        send("R5", 5'd6, 64'h0000_0000_0001_0000, 64'd0, 5'd2, 16'h57FF, 2'b10, 1'b0, 1'b1);
        idle(2);
        // R6: indexed, with wrap-around, immediate ignored
        send("R6", 5'd7, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 5'd2, 16'hFFFF, 2'b11, 1'b0, 1'b0);
        send("R2", 5'd0, 64'h1234, 64'h0000_0000_CAFE_0000, 5'd2, 16'h1234, 2'b11, 1'b0, 1'b1);
        // R7: valid updating load; base is register value
        send("R7", 5'd4, 64'h0000_0000_0000_4000, 64'd0, 5'd9, 16'hFFF8, 2'b00, 1'b1, 1'b0);
        send("R7", 5'd12, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0010, 5'd9, 16'd0, 2'b11, 1'b1, 1'b0);
        // R8: updating load with base 0 (register value still used) and clash
        send("R8", 5'd0, 64'h0000_0000_0000_0100, 64'd0, 5'd9, 16'h0010, 2'b00, 1'b1, 1'b0);
        send("R8", 5'd9, 64'h0000_0000_0000_0200, 64'd0, 5'd9, 16'h0004, 2'b01, 1'b1, 1'b0);
        idle(1);
        // R9: updating store, source equals base is valid; base 0 invalid
        send("R9", 5'd6, 64'h0000_0000_0000_3000, 64'd0, 5'd6, 16'h0008, 2'b00, 1'b1, 1'b1);
        send("R9", 5'd0, 64'h0000_0000_0000_3000, 64'd0, 5'd6, 16'h0008, 2'b00, 1'b1, 1'b1);
        // R10: non-updating with clashing indices stays quiet
        send("R10", 5'd8, 64'h0000_0000_0000_0500, 64'd0, 5'd8, 16'h0002, 2'b10, 1'b0, 1'b0);
        send("R10", 5'd0, 64'h0000_0000_0000_0500, 64'd0, 5'd0, 16'h0002, 2'b00, 1'b0, 1'b1);
        idle(3);

        if (exp_q.size() != 0)
            check("R1", "results missing", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule